// File: doc/BRIEF.md
# Clock Status Flag and Interrupt Register

This block is the status and interrupt front end of a clock and reset generator. It watches six event and status inputs: a periodic-timer expiry pulse, three reset-cause indications (power-on, low-voltage and illegal-address), the PLL lock status and the self-clock-mode status. It turns them into an 8-bit flag register that software reads and clears. Event flags are sticky and clear only when software writes 1 to them. Two of them record any change of a live status bit, whether it rises or falls. The live lock and mode bits are read-only mirrors of their inputs.

A second register holds three interrupt enables, one each for the timer, lock-change and mode-change flags. The block drives one registered interrupt request, which is the OR of each enabled event flag. The reset-cause flags are captured while reset is asserted and never raise an interrupt. Access uses a simple synchronous bus: a write strobe with address and data, and read data that is decoded combinationally from the address.

Top module: `clkstat_regs`

## Requirements
- R1: While rst_n is low at a clock edge, the timer, lock-change and mode-change flags and all enables clear, irq_o clears, and the power-on, low-voltage and illegal-address flags load the values of their cause inputs.
- R2: A write to the flag register (address 0) clears each sticky flag whose data bit is 1 (bits 7, 6, 5, 4, 2, 1). A 0 in the data leaves the flag unchanged.
- R3: A high tick_i at a clock edge sets the timer flag (flag bit 7).
- R4: Flag bit 3 reads the effective lock status one edge after the input is sampled. The lock-change flag (bit 4) sets at the edge where that status changes, whether it rises or falls.
- R5: Flag bit 0 reads the self-clock-mode status one edge after the input is sampled. The mode-change flag (bit 1) sets at the edge where that status changes, whether it rises or falls.
- R6: The effective lock status is lock_i AND NOT scm_i, so bit 3 reads 0 while bit 0 reads 1.
- R7: Writes to bits 3 and 0 have no effect. After reset, changes on the three cause inputs have no effect on the flags.
- R8: The enable register (address 1) stores data bits 7, 4 and 1 and reads 0 in every other bit. Any other address reads 0.
- R9: irq_o is the OR of (flag bit 7 AND enable bit 7), (flag bit 4 AND enable bit 4) and (flag bit 1 AND enable bit 1), taken one edge later. Reset-cause flags never drive it.
- R10: If a set event and a write-1 clear of the same flag occur at the same edge, the flag is set.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Periodic timer end-of-period pulse |
| lock_i | input | 1 | PLL lock status |
| scm_i | input | 1 | Self-clock-mode status |
| por_cause_i | input | 1 | Power-on reset cause, sampled during reset |
| lvr_cause_i | input | 1 | Low-voltage reset cause, sampled during reset |
| ila_cause_i | input | 1 | Illegal-address reset cause, sampled during reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every status and event input is already synchronous to clk and stays stable between edges, and that reset is held for at least one edge. The bench drives all inputs at the falling edge only. It holds reset for several edges, and it toggles lock and mode at random rates, including cycles where both change together and where a write-1 clear lands on a flag that is being set.

// File: rtl/clkstat_pkg.sv
`timescale 1ns/1ps
// Package: bit positions and masks shared by the status register blocks.
// Assumes an 8-bit register width; positions are fixed by the software view.
package clkstat_pkg;
    localparam int REG_W  = 8;
    localparam int B_TMR  = 7;
    localparam int B_POR  = 6;
    localparam int B_LVR  = 5;
    localparam int B_LCHG = 4;
    localparam int B_LOCK = 3;
    localparam int B_ILA  = 2;
    localparam int B_MCHG = 1;
    localparam int B_MODE = 0;
    localparam logic [REG_W-1:0] W1C_MASK = 8'hF6;
    localparam logic [REG_W-1:0] IRQ_MASK = 8'h92;
endpackage

// File: rtl/clkstat_chg.sv
`timescale 1ns/1ps
// Module: registers one live status bit and keeps a sticky change flag.
// The flag sets when the input differs from the registered copy; a write-1
// clear loses against a simultaneous change. Assumes live_i is synchronous.
module clkstat_chg (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic clr_i,
    output logic stat_o,
    output logic flag_o
);
    logic stat_q;
    logic flag_q;

    // Track the live bit and latch any change of it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= live_i;
            flag_q <= 1'b0;
        end else begin
            stat_q <= live_i;
            flag_q <= (live_i != stat_q) | (flag_q & ~clr_i);
        end
    end

    assign stat_o = stat_q;
    assign flag_o = flag_q;

    // R4 (and R5 for the mode instance): every status change leaves the flag set.
    assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (stat_q != $past(stat_q))) |-> flag_q);
endmodule

// File: rtl/clkstat_flags.sv
`timescale 1ns/1ps
// Module: the 8-bit flag register. Holds the timer flag, the reset-cause
// flags and two change detectors. clr_i is an already decoded write-1 mask.
// Assumes all inputs are synchronous to clk.
module clkstat_flags
    import clkstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             lock_i,
    input  logic             scm_i,
    input  logic             por_i,
    input  logic             lvr_i,
    input  logic             ila_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] flags_o
);
    localparam int NCHG = 2;

    logic            tmr_q, por_q, lvr_q, ila_q;
    logic [NCHG-1:0] live, chg_clr, chg_stat, chg_flag;

    // Index 1 carries lock (masked by self-clock mode), index 0 the mode bit.
    assign live    = {lock_i & ~scm_i, scm_i};
    assign chg_clr = {clr_i[B_LCHG], clr_i[B_MCHG]};

    genvar g;
    generate
        for (g = 0; g < NCHG; g++) begin : g_chg
            clkstat_chg u_chg (
                .clk    (clk),
                .rst_n  (rst_n),
                .live_i (live[g]),
                .clr_i  (chg_clr[g]),
                .stat_o (chg_stat[g]),
                .flag_o (chg_flag[g])
            );
        end
    endgenerate

    // Timer flag: set on tick, write-1 clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= 1'b0;
        else        tmr_q <= tick_i | (tmr_q & ~clr_i[B_TMR]);
    end

    // Reset-cause flags: captured during reset, only cleared afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q <= por_i;
            lvr_q <= lvr_i;
            ila_q <= ila_i;
        end else begin
            por_q <= por_q & ~clr_i[B_POR];
            lvr_q <= lvr_q & ~clr_i[B_LVR];
            ila_q <= ila_q & ~clr_i[B_ILA];
        end
    end

    assign flags_o = {tmr_q, por_q, lvr_q, chg_flag[1], chg_stat[1],
                      ila_q, chg_flag[0], chg_stat[0]};

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> flags_o[B_TMR]);
    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[B_TMR] && !tick_i) |=> !flags_o[B_TMR]);
    assert_lock_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[B_MODE] |-> !flags_o[B_LOCK]);
    assert_cause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$rose(por_q) && !$rose(lvr_q) && !$rose(ila_q));
endmodule

// File: rtl/clkstat_irqen.sv
`timescale 1ns/1ps
// Module: interrupt-enable register and registered combined request.
// Only the enable bit positions in IRQ_MASK are stored; the rest read 0.
module clkstat_irqen
    import clkstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] flags_i,
    output logic [REG_W-1:0] en_o,
    output logic             irq_o
);
    logic [REG_W-1:0] en_q;
    logic             irq_q;

    // Enable register: keep only implemented enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= wdata_i & IRQ_MASK;
    end

    // Combined request, registered once.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags_i & en_q & IRQ_MASK);
    end

    assign en_o  = en_q;
    assign irq_o = irq_q;

    assert_no_irq_wo_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_o);
    assert_no_cause_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & IRQ_MASK) == '0) |=> !irq_o);
endmodule

// File: rtl/clkstat_regs.sv
`timescale 1ns/1ps
// Module: top of the clock status register block. Decodes the simple
// synchronous bus into a write-1 clear mask and an enable write, and muxes
// read data from the address. Assumes inputs are synchronous to clk.
module clkstat_regs
    import clkstat_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int FLAG_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              lock_i,
    input  logic              scm_i,
    input  logic              por_cause_i,
    input  logic              lvr_cause_i,
    input  logic              ila_cause_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);

    logic             sel_flag, sel_en;
    logic [REG_W-1:0] clr, flags, en;

    assign sel_flag = (addr_i == A_FLAG);
    assign sel_en   = (addr_i == A_EN);
    assign clr      = (wr_en_i && sel_flag) ? (wdata_i & W1C_MASK) : '0;

    clkstat_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .lock_i  (lock_i),
        .scm_i   (scm_i),
        .por_i   (por_cause_i),
        .lvr_i   (lvr_cause_i),
        .ila_i   (ila_cause_i),
        .clr_i   (clr),
        .flags_o (flags)
    );

    clkstat_irqen u_irqen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en_i && sel_en),
        .wdata_i (wdata_i),
        .flags_i (flags),
        .en_o    (en),
        .irq_o   (irq_o)
    );

    // Read mux: flag register, enable register, else zero.
    always_comb begin
        if (sel_flag)    rdata_o = flags;
        else if (sel_en) rdata_o = en;
        else             rdata_o = '0;
    end

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |-> ((rdata_o & ~IRQ_MASK) == '0));
endmodule

// File: tb/sim_clkstat_regs.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, all compared
// against a bench-side model of the register behaviour.
module sim_clkstat_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, lock = 1'b0, scm = 1'b0;
    logic       por = 1'b0, lvr = 1'b0, ila = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_flg = 8'd0;
    logic [7:0] m_en  = 8'd0;
    logic       m_irq = 1'b0;
    bit         m_ok  = 0;

    always #10 clk = ~clk;

    clkstat_regs u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .lock_i(lock), .scm_i(scm),
        .por_cause_i(por), .lvr_cause_i(lvr), .ila_cause_i(ila),
        .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [7:0] m_read(input logic [1:0] a);
        if (a == 2'd0) return m_flg;
        if (a == 2'd1) return m_en;
        return 8'd0;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Advance the model by one clock edge from the current bench inputs.
    task automatic m_edge();
        logic [7:0] clr, n;
        logic leff;
        leff = lock & ~scm;
        if (!rst_n) begin
            m_flg = {1'b0, por, lvr, 1'b0, leff, ila, 1'b0, scm};
            m_en  = 8'd0;
            m_irq = 1'b0;
        end else begin
            clr   = (we && addr == 2'd0) ? (wdata & 8'hF6) : 8'd0;
            m_irq = |(m_flg & m_en & 8'h92);
            n     = m_flg;
            n[7]  = tick | (m_flg[7] & ~clr[7]);
            n[6]  = m_flg[6] & ~clr[6];
            n[5]  = m_flg[5] & ~clr[5];
            n[2]  = m_flg[2] & ~clr[2];
            n[4]  = (leff != m_flg[3]) | (m_flg[4] & ~clr[4]);
            n[1]  = (scm != m_flg[0]) | (m_flg[1] & ~clr[1]);
            n[3]  = leff;
            n[0]  = scm;
            m_flg = n;
            if (we && addr == 2'd1) m_en = wdata & 8'h92;
        end
        m_ok = 1;
    endtask

    // One cycle: drive at falling edge, check, then take the rising edge.
    task automatic step(input string tag, input logic tk, input logic lk, input logic sc,
                        input logic w, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = tk; lock = lk; scm = sc; we = w; addr = a; wdata = d;
        #1;
        if (m_ok) begin
            check(tag, rdata, m_read(a));
            check({tag, " irq R9"}, {7'd0, irq}, {7'd0, m_irq});
        end
        @(posedge clk);
        m_edge();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset with power-on and illegal-address causes present.
        por = 1'b1; lvr = 1'b0; ila = 1'b1; rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        @(negedge clk); rst_n = 1'b1; addr = 2'd0; #1;
        check("R1 flags", rdata, 8'h44);
        addr = 2'd1; #1;
        check("R1 enables", rdata, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        // R7: cause inputs and writes to live bits have no effect.
        por = 1'b0; ila = 1'b0; lvr = 1'b1;
        step("R7 live write", 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h09);
        step("R7 check", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        @(negedge clk); addr = 2'd0; #1;
        check("R7 flags", rdata, 8'h44);
        // R2: write 0 leaves, write 1 clears.
        step("R2 w0", 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00);
        step("R2 w1", 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h40);
        step("R2 after", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        // R8: enables write, reserved bits, unused address.
        step("R8 en write", 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'hFF);
        step("R8 en read", 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00);
        step("R8 unused", 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'hFF);
        step("R8 unused rd", 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 8'h00);
        // R3 and R9: tick sets flag, irq follows.
        step("R3 tick", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        step("R3 flag", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        step("R9 irq", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        // R10: set and clear together.
        step("R10 collide", 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h80);
        step("R10 after", 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h80);
        step("R10 cleared", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        // R4: lock rises and falls.
        step("R4 rise", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
        step("R4 seen", 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'h10);
        step("R4 fall", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        step("R4 seen2", 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h10);
        // R5 and R6: mode toggles while lock is held high.
        step("R5 lock", 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'hFF);
        step("R6 mode on", 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h12);
        step("R6 masked", 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
        step("R5 mode off", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
        step("R5 seen", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
        // Random traffic covering R2 R3 R4 R5 R6 R8 R9 R10.
        for (int i = 0; i < 4000; i++) begin
            logic tk, lk, sc, w;
            tk = ($urandom % 8) == 0;
            lk = (($urandom % 10) == 0) ? ~lock : lock;
            sc = (($urandom % 20) == 0) ? ~scm : scm;
            w  = ($urandom % 4) == 0;
            por = $urandom; lvr = $urandom; ila = $urandom;
            step("R2 R3 R4 R5 R6 R8 R10 random", tk, lk, sc, w,
                 2'($urandom), 8'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule